// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog timer for a small processor. Software reaches it through a simple register port of four 8-bit locations. A control register selects run or stop, watchdog or timer behaviour, and a prescale setting. A reload register holds the count. A prescaler and a down counter advance on a single-cycle watchdog clock strobe. The settings that drive the counting live in a shadow copy of the control register.

Software restarts the count with a keyed feed: two writes with fixed key values, in a fixed order, with no other write between them. Any mistake in that sequence pulls the reset request at once. In watchdog mode the block is strict in two ways. The shadow only takes new settings on a good feed, and a control write must be followed straight away by a feed. On expiry, watchdog mode raises a one-clock reset request. Timer mode instead sets a sticky overflow flag and starts the next period.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, reset_req and ovf_flag are 0 and all four read locations return 0.
- R2: A write of A5h to address 2 followed by a write of 5Ah to address 3 is a valid feed. Reads between the two are allowed. A valid feed loads the reload value into the down counter and restarts the prescaler.
- R3: Each of the following drives reset_req high for exactly one clock, in the cycle after the offending write: a value other than A5h written to address 2; a write to address 3 not preceded by a good first key; any other write between the two keys.
- R4: A control write is made while the control mode bit is 1, or with bit 1 of the written data set. The next register write must then be the first key, otherwise reset_req pulses. Control writes in timer mode with mode bit 0 in the data need no feed.
- R5: In watchdog mode, the shadow (read at address 3, bits {pre,mode,run} at [4:0]) changes only on a valid feed. In timer mode it copies the control register every clock.
- R6: With shadow run set, a strobe on every clock expires the counter (W+1)·2^(5+P)+1 strobes after a feed, where W is the reload value and P is the prescale field. The counter does not move without a strobe, or while run is clear.
- R7: Expiry in watchdog mode gives a one-clock reset_req. The same edge clears the shadow, the counter and the prescaler to 0.
- R8: Expiry in timer mode sets ovf_flag, does not raise reset_req, and reloads the counter, so that the next period has the same length.
- R9: ovf_flag (also control bit 7) stays set until a control write with bit 7 equal to 0. Writing 1 there has no effect.
- R10: Register map. Address 0 is control: bit 0 run, bit 1 mode (1 = watchdog), bits 4:2 prescale, bit 7 overflow. Address 1 is reload. Address 2 is the first key on write and the counter on read. Address 3 is the second key on write and the shadow on read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_en | input | 1 | Single-cycle watchdog clock strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| reset_req | output | 1 | One-clock reset request |
| ovf_flag | output | 1 | Sticky timer-mode overflow flag |

## Verification
The assertions take three things for granted about the inputs. Register writes never come on two consecutive cycles, so a second faulty write cannot stretch the reset pulse. No write arrives in the cycle where a strobe expires the counter. The overflow flag is only cleared by an explicit control write. The bench meets all three: every write is a one-cycle strobe followed by an idle cycle, and the strobe is held low whenever registers are written. Timeout lengths are swept over several prescale and reload settings in both modes, and each is compared against the closed-form count.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3,
  parameter int PRE_BASE = 5,
  parameter logic [7:0] KEY_A = 8'hA5,
  parameter logic [7:0] KEY_B = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wclk_en,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reset_req,
  output logic       ovf_flag
);
  localparam int PS_W = PRE_BASE + (1 << PRE_W) - 1;
  localparam int SH_W = PRE_W + 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_KEY1 = 2'd2, A_KEY2 = 2'd3;

  logic             run_q, mode_q, ovf_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] load_q;
  logic [SH_W-1:0]  shadow_q;
  logic [CNT_W:0]   cnt_q;
  logic [PS_W-1:0]  ps_q;
  logic             armed_q, pend_q;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_load = reg_wr && reg_addr == A_LOAD;
  wire wr_k1   = reg_wr && reg_addr == A_KEY1;
  wire wr_k2   = reg_wr && reg_addr == A_KEY2;
  wire key1_ok = wr_k1 && reg_wdata == KEY_A && !armed_q;
  wire key2_ok = wr_k2 && reg_wdata == KEY_B && armed_q;
  wire fault   = reg_wr && !key1_ok && !key2_ok && (armed_q || pend_q || wr_k1 || wr_k2);

  wire             sh_run  = shadow_q[0];
  wire             sh_mode = shadow_q[1];
  wire [PRE_W-1:0] sh_pre  = shadow_q[SH_W-1:2];
  wire [PS_W-1:0]  ps_top  = {PS_W{1'b1}} >> (PS_W - PRE_BASE - int'(sh_pre));
  wire tick   = wclk_en && sh_run;
  wire expire = tick && cnt_q[CNT_W];
  wire bite   = fault || (expire && sh_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run_q, mode_q, ovf_q, pre_q} <= '0;
      load_q    <= '0;
      shadow_q  <= '0;
      cnt_q     <= '0;
      ps_q      <= '0;
      armed_q   <= 1'b0;
      pend_q    <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= bite;

      if (wr_ctrl) begin
        run_q  <= reg_wdata[0];
        mode_q <= reg_wdata[1];
        pre_q  <= reg_wdata[SH_W-1:2];
        ovf_q  <= ovf_q & reg_wdata[7];
      end
      if (expire && !sh_mode) ovf_q <= 1'b1;
      if (wr_load) load_q <= reg_wdata[CNT_W-1:0];

      if (bite) begin
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (reg_wr) begin
        armed_q <= key1_ok;
        pend_q  <= wr_ctrl && (mode_q || reg_wdata[1]);
      end

      if (bite) shadow_q <= '0;
      else if (key2_ok || !mode_q) shadow_q <= {pre_q, mode_q, run_q};

      if (bite) begin
        cnt_q <= '0;
        ps_q  <= '0;
      end else if (key2_ok || expire) begin
        cnt_q <= {1'b0, load_q};
        ps_q  <= '0;
      end else if (tick) begin
        if (ps_q >= ps_top) begin
          ps_q  <= '0;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          ps_q <= ps_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[SH_W-1:0] = {pre_q, mode_q, run_q};
        reg_rdata[7]        = ovf_q;
      end
      A_LOAD:  reg_rdata[CNT_W-1:0] = load_q;
      A_KEY1:  reg_rdata[CNT_W-1:0] = cnt_q[CNT_W-1:0];
      default: reg_rdata[SH_W-1:0]  = shadow_q;
    endcase
  end

  assign ovf_flag = ovf_q;
endmodule

module wdt_keyed_chk #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3,
  parameter logic [7:0] KEY_A = 8'hA5,
  parameter logic [7:0] KEY_B = 8'h5A
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wclk_en,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             reset_req,
  input logic             ovf_flag,
  input logic [PRE_W+1:0] shadow,
  input logic [CNT_W:0]   cnt
);
  p_bad_key1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd2 && reg_wdata != KEY_A |=> reset_req);
  p_bad_key2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd3 && reg_wdata != KEY_B |=> reset_req);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> shadow == '0 && cnt == '0);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wclk_en && !reg_wr |=> $stable(cnt));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(reg_wr && reg_addr == 2'd0 && !reg_wdata[7]) |=> ovf_flag);
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wclk_en(wclk_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reset_req(reset_req), .ovf_flag(ovf_flag),
  .shadow(shadow_q), .cnt(cnt_q)
);

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wclk_en = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reset_req, ovf_flag;

  int n_chk = 0, n_fail = 0;
  logic rr_seen;
  logic rr_any;

  wdt_keyed dut (.clk(clk), .rst_n(rst_n), .wclk_en(wclk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reset_req(reset_req), .ovf_flag(ovf_flag));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; wclk_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    rr_seen = reset_req;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic strobe_n(input int k);
    rr_any = 1'b0;
    @(negedge clk);
    wclk_en = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (reset_req) rr_any = 1'b1;
    end
    wclk_en = 1'b0;
  endtask

  task automatic run_until(input bit want_ovf, input int limit, output int n);
    logic hit;
    hit = 1'b0; n = 0; rr_any = 1'b0;
    @(negedge clk);
    wclk_en = 1'b1;
    while (!hit && n < limit) begin
      @(negedge clk);
      n++;
      if (reset_req) rr_any = 1'b1;
      hit = want_ovf ? ovf_flag : reset_req;
    end
    wclk_en = 1'b0;
  endtask

  function automatic int t_len(input int p, input int w);
    return (w + 1) * (1 << (5 + p)) + 1;
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int v, n, t;
    int wl[3];
    wl[0] = 0; wl[1] = 1; wl[2] = 5;

    do_reset();
    @(negedge clk);
    check("R1 reset_req", int'(reset_req), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 read", v, 0);
    end

    wr(2'd1, 8'h37); rd(2'd1, v); check("R10 reload read", v, 8'h37);
    wr(2'd0, 8'h0D); rd(2'd0, v); check("R10 ctrl read", v, 8'h0D);

    do_reset();
    wr(2'd2, 8'h00); check("R3 wrong key1", int'(rr_seen), 1);
    @(negedge clk); check("R3 one-clock pulse", int'(reset_req), 0);
    wr(2'd3, 8'h5A); check("R3 key2 alone", int'(rr_seen), 1);
    wr(2'd2, 8'hA5); check("R3 key1 ok", int'(rr_seen), 0);
    wr(2'd1, 8'h10); check("R3 write between keys", int'(rr_seen), 1);
    wr(2'd2, 8'hA5); wr(2'd2, 8'hA5); check("R3 key1 twice", int'(rr_seen), 1);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h55); check("R3 wrong key2", int'(rr_seen), 1);

    do_reset();
    wr(2'd1, 8'd9);
    wr(2'd2, 8'hA5);
    rd(2'd0, v); rd(2'd2, v);
    wr(2'd3, 8'h5A); check("R2 feed with reads between", int'(rr_seen), 0);
    rd(2'd2, v); check("R2 counter loaded", v, 9);

    do_reset();
    wr(2'd0, 8'h03); check("R4 ctrl write", int'(rr_seen), 0);
    wr(2'd1, 8'h05); check("R4 no feed after ctrl", int'(rr_seen), 1);

    do_reset();
    wr(2'd0, 8'h03);
    rd(2'd3, v); check("R5 shadow holds before feed", v, 0);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A); check("R4 feed after ctrl", int'(rr_seen), 0);
    rd(2'd3, v); check("R5 shadow after feed", v, 8'h03);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01); check("R4 leaving wd mode needs feed", int'(rr_seen), 1);

    do_reset();
    wr(2'd0, 8'h0C); wr(2'd1, 8'h04); check("R4 timer ctrl needs no feed", int'(rr_seen), 0);
    wr(2'd0, 8'h1D);
    @(negedge clk);
    rd(2'd3, v); check("R5 timer shadow follows", v, 8'h1D);

    do_reset();
    wr(2'd1, 8'd3); wr(2'd0, 8'h00);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    strobe_n(100);
    rd(2'd2, v); check("R6 no count while stopped", v, 3);
    wr(2'd0, 8'h01);
    @(negedge clk);
    strobe_n(40);
    rd(2'd2, v); check("R6 count after 40 strobes", v, 2);

    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 3; i++) begin
        t = t_len(p, wl[i]);
        do_reset();
        wr(2'd1, 8'(wl[i]));
        wr(2'd0, 8'((p << 2) | 1));
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
        run_until(1'b1, t + 5, n);
        check("R6 timer timeout", n, t);
        check("R8 no reset in timer mode", int'(rr_any), 0);
        wr(2'd0, 8'((p << 2) | 1));
        check("R9 cleared by 0", int'(ovf_flag), 0);
        run_until(1'b1, t + 5, n);
        check("R8 reloaded period", n, t);
      end
    end

    do_reset();
    wr(2'd1, 8'd0); wr(2'd0, 8'h1D);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    run_until(1'b1, t_len(7, 0) + 5, n);
    check("R6 longest prescale", n, t_len(7, 0));
    wr(2'd0, 8'h9D);
    rd(2'd0, v); check("R9 write 1 keeps flag", v, 8'h9D);
    wr(2'd0, 8'h1D);
    rd(2'd0, v); check("R9 write 0 clears flag", v, 8'h1D);

    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 4; w += 3) begin
        t = t_len(p, w);
        do_reset();
        wr(2'd1, 8'(w));
        wr(2'd0, 8'((p << 2) | 3));
        wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
        check("R4 wd setup", int'(rr_seen), 0);
        run_until(1'b0, t + 5, n);
        check("R6 watchdog timeout", n, t);
        @(negedge clk);
        check("R7 pulse one clock", int'(reset_req), 0);
        rd(2'd3, v); check("R7 shadow cleared", v, 0);
        rd(2'd2, v); check("R7 counter cleared", v, 0);
      end
    end

    do_reset();
    wr(2'd1, 8'd0); wr(2'd0, 8'h03);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    strobe_n(20);
    check("R2 alive before refeed", int'(rr_any), 0);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    strobe_n(20);
    check("R2 refeed restarts count", int'(rr_any), 0);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    run_until(1'b0, 40, n);
    check("R2 timeout from last feed", n, 33);

    summary();
    $finish;
  end
endmodule